// File: doc/BRIEF.md
# Serial Flash Software-Reset Sequencer

This block is the device-side logic of a serial NOR flash that carries out the two-command software reset. It watches a single-line SPI slave interface: an active-low chip select, a serial clock and one data input. All three are brought into the system clock domain through synchronizers. Each selection is decoded as an 8-bit opcode. An arming opcode (0x66) prepares the block. An executing opcode (0x99) then produces an internal reset pulse, but only if it follows the arming command directly, arrives after a long enough deselect gap, and ends with a chip-select rise.

When the reset fires, the block emits a strobe that returns the volatile registers to their power-on values. It presents those values, derived from a nonvolatile configuration word. It aborts any program, write or erase that is running or suspended. It drops a ready flag for a recovery window, and any selection that begins inside that window is ignored. Arming is refused while a status-register write or a nonvolatile-configuration write is still busy.

Top module: `flash_rst_seq`

## Requirements
- R1: The opcode is the first 8 bits sampled on rising serial-clock edges while chip select is low, most significant bit first. A selection with fewer than 8 bits is discarded and leaves the armed state unchanged. Bits after the eighth are ignored.
- R2: `rst_pulse` is high for exactly one cycle, shortly after the chip-select rise that ends a complete 0x99 command. This happens only when the block is armed by the command directly before it.
- R3: Any completed, non-ignored command clears the armed state, unless it is an accepted 0x66. A 0x99 clears the armed state whether or not it fires.
- R4: The synchronized chip select must stay high for at least DESEL_MIN system-clock cycles before the 0x99 selection begins. With a shorter gap, no reset fires and the armed state is lost.
- R5: A selection that begins within RECOV_MIN cycles after the chip-select rise that fired a reset is ignored completely. A selection that begins later is decoded normally.
- R6: `flag_rdy` is 1 after reset. It is 0 from the `rst_pulse` cycle until the recovery window ends, then returns to 1.
- R7: `vol_clr` is high in exactly the cycles where `rst_pulse` is high.
- R8: The default outputs are combinational functions of `nv_cfg`: `vcr_dflt` = {nv_cfg[15:12], 4'b1011}, `evcr_dflt` = {nv_cfg[3:2], 2'b11, nv_cfg[4], 3'b111}, `ear_dflt` = {7'b0, nv_cfg[1]}.
- R9: `abort_op` pulses together with `rst_pulse` if `op_active` or `op_susp` is high at the firing moment. Otherwise it stays low.
- R10: A 0x66 that completes while `wrsr_busy` or `wnvcr_busy` is high does not arm the block, and it still clears any earlier arming.
- R11: After `rst_n`, the block is unarmed, with `rst_pulse`, `vol_clr` and `abort_op` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low (asynchronous) |
| sclk | input | 1 | SPI serial clock, mode 0 (asynchronous) |
| dq0 | input | 1 | SPI serial data input (asynchronous) |
| wrsr_busy | input | 1 | Status-register write in progress |
| wnvcr_busy | input | 1 | Nonvolatile-configuration write in progress |
| op_active | input | 1 | Program, write or erase running |
| op_susp | input | 1 | Program, write or erase suspended |
| nv_cfg | input | 16 | Nonvolatile configuration word |
| rst_pulse | output | 1 | One-cycle internal reset pulse |
| vol_clr | output | 1 | Strobe that reloads the volatile registers to defaults |
| abort_op | output | 1 | Strobe that aborts the running or suspended operation |
| flag_rdy | output | 1 | Flag-status ready bit |
| vcr_dflt | output | 8 | Power-on value for the volatile configuration register |
| evcr_dflt | output | 8 | Power-on value for the enhanced volatile configuration register |
| ear_dflt | output | 8 | Power-on value for the extended address register |

## Verification
The bench sweeps the deselect gap across DESEL_MIN±2 and the post-reset gap across RECOV_MIN±1. An off-by-one in either counter would fire on a gap one cycle short, or would accept or drop the selection that lands exactly on the boundary. It places every one of the 256 opcodes between the arm and execute commands. A design that left the arming in place after a foreign command would then reset on the stale arm. Partial and over-long selections, busy combinations and abort combinations catch a receiver that treats a short selection as a command, and catch a busy or abort qualifier that is ignored or wired to the wrong signal.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int unsigned OPC_W = 8;
  localparam int unsigned CFG_W = 16;
  localparam int unsigned REG_W = 8;
  localparam logic [OPC_W-1:0] OPC_ARM  = 8'h66;
  localparam logic [OPC_W-1:0] OPC_EXEC = 8'h99;

  function automatic logic [REG_W-1:0] cfg_to_vcr(input logic [CFG_W-1:0] c);
    return {c[15:12], 4'b1011};
  endfunction

  function automatic logic [REG_W-1:0] cfg_to_evcr(input logic [CFG_W-1:0] c);
    return {c[3:2], 2'b11, c[4], 3'b111};
  endfunction

  function automatic logic [REG_W-1:0] cfg_to_ear(input logic [CFG_W-1:0] c);
    return {7'b0, c[1]};
  endfunction
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int unsigned W = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stg
      logic [W-1:0] q_r;
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) q_r <= RST_VAL;
          else        q_r <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) q_r <= RST_VAL;
          else        q_r <= g_stg[i-1].q_r;
      end
    end
  endgenerate

  assign q = g_stg[STAGES-1].q_r;
endmodule

// File: rtl/rstseq_rx.sv
module rstseq_rx #(
  parameter int unsigned OPC_W = 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_s,
  input  logic             sclk_s,
  input  logic             dq_s,
  output logic             sel_start,
  output logic             sel_end,
  output logic             cmd_done,
  output logic [OPC_W-1:0] cmd_code
);
  localparam int unsigned BCW = $clog2(OPC_W + 1);

  logic           cs_d, sclk_d, sclk_rise;
  logic [BCW-1:0] bitcnt;
  logic [OPC_W-1:0] sreg;

  assign sel_start = cs_d & ~cs_s;
  assign sel_end   = ~cs_d & cs_s;
  assign sclk_rise = sclk_s & ~sclk_d & ~cs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
      bitcnt <= '0;
      sreg   <= '0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
      if (sel_start) begin
        bitcnt <= '0;
        sreg   <= '0;
      end else if (sclk_rise && bitcnt < BCW'(OPC_W)) begin
        sreg   <= {sreg[OPC_W-2:0], dq_s};
        bitcnt <= bitcnt + 1'b1;
      end
    end
  end

  assign cmd_done = sel_end && (bitcnt == BCW'(OPC_W));
  assign cmd_code = sreg;
endmodule

// File: rtl/rstseq_gap.sv
module rstseq_gap #(
  parameter int unsigned MIN = 50
)(
  input  logic clk,
  input  logic rst_n,
  input  logic hi,
  input  logic rise,
  output logic met
);
  localparam int unsigned CW = $clog2(MIN + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN);

  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v < CMAX) ? v + 1'b1 : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= CMAX;
    else if (rise)   cnt <= sat_inc('0);
    else if (hi)     cnt <= sat_inc(cnt);
  end

  assign met = (cnt >= CMAX);
endmodule

// File: rtl/rstseq_recov.sv
module rstseq_recov #(
  parameter int unsigned HOLD = 3000
)(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt;
  logic          on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on  <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      on  <= 1'b1;
      cnt <= '0;
    end else if (on) begin
      if (cnt == LAST) on  <= 1'b0;
      else             cnt <= cnt + 1'b1;
    end
  end

  assign busy = on;
endmodule

// File: rtl/flash_rst_seq.sv
module flash_rst_seq
  import rstseq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DESEL_MIN   = 50,
  parameter int unsigned RECOV_MIN   = 3000
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             dq0,
  input  logic             wrsr_busy,
  input  logic             wnvcr_busy,
  input  logic             op_active,
  input  logic             op_susp,
  input  logic [CFG_W-1:0] nv_cfg,
  output logic             rst_pulse,
  output logic             vol_clr,
  output logic             abort_op,
  output logic             flag_rdy,
  output logic [REG_W-1:0] vcr_dflt,
  output logic [REG_W-1:0] evcr_dflt,
  output logic [REG_W-1:0] ear_dflt
);
  logic [2:0]       pins_s;
  logic             cs_s, sclk_s, dq_s;
  logic             sel_start, sel_end, cmd_done;
  logic [OPC_W-1:0] cmd_code;
  logic             gap_met, rec_busy;
  logic             frame_blk, frame_gap_ok;
  logic             armed, wr_busy;
  logic             accept, is_arm, is_exec, fire;

  rstseq_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, dq0}), .q(pins_s));

  assign cs_s   = pins_s[2];
  assign sclk_s = pins_s[1];
  assign dq_s   = pins_s[0];

  rstseq_rx #(.OPC_W(OPC_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sclk_s(sclk_s), .dq_s(dq_s),
    .sel_start(sel_start), .sel_end(sel_end), .cmd_done(cmd_done),
    .cmd_code(cmd_code));

  rstseq_gap #(.MIN(DESEL_MIN)) u_gap (
    .clk(clk), .rst_n(rst_n), .hi(cs_s), .rise(sel_end), .met(gap_met));

  rstseq_recov #(.HOLD(RECOV_MIN)) u_recov (
    .clk(clk), .rst_n(rst_n), .start(fire), .busy(rec_busy));

  // per-selection qualifiers captured when chip select falls
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_blk    <= 1'b0;
      frame_gap_ok <= 1'b0;
    end else if (sel_start) begin
      frame_blk    <= rec_busy;
      frame_gap_ok <= gap_met;
    end
  end

  assign wr_busy = wrsr_busy | wnvcr_busy;
  assign accept  = cmd_done & ~frame_blk;
  assign is_arm  = accept & (cmd_code == OPC_ARM);
  assign is_exec = accept & (cmd_code == OPC_EXEC);
  assign fire    = is_exec & armed & frame_gap_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      rst_pulse <= 1'b0;
      vol_clr   <= 1'b0;
      abort_op  <= 1'b0;
    end else begin
      if (accept) armed <= is_arm & ~wr_busy;
      rst_pulse <= fire;
      vol_clr   <= fire;
      abort_op  <= fire & (op_active | op_susp);
    end
  end

  assign flag_rdy  = ~rec_busy;
  assign vcr_dflt  = cfg_to_vcr(nv_cfg);
  assign evcr_dflt = cfg_to_evcr(nv_cfg);
  assign ear_dflt  = cfg_to_ear(nv_cfg);
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_start,
  input logic       cmd_done,
  input logic [7:0] cmd_code,
  input logic       wr_busy,
  input logic       armed,
  input logic       rec_busy,
  input logic       frame_blk,
  input logic       rst_pulse,
  input logic       vol_clr,
  input logic       abort_op,
  input logic       flag_rdy
);
  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);

  assert_pulse_from_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> $past(cmd_done && cmd_code == 8'h99));

  assert_clr_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_pulse || vol_clr) |-> (rst_pulse && vol_clr));

  assert_abort_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_op |-> rst_pulse);

  assert_flag_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> !flag_rdy);

  assert_busy_refuse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && cmd_code == 8'h66 && wr_busy) |=> !armed);

  assert_recov_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_start && rec_busy) |=> frame_blk);
endmodule

bind flash_rst_seq rstseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_start(sel_start), .cmd_done(cmd_done),
  .cmd_code(cmd_code), .wr_busy(wr_busy), .armed(armed), .rec_busy(rec_busy),
  .frame_blk(frame_blk), .rst_pulse(rst_pulse), .vol_clr(vol_clr),
  .abort_op(abort_op), .flag_rdy(flag_rdy));

// File: tb/flash_rst_seq_tb.sv
`timescale 1ns/1ps
module flash_rst_seq_tb_top;
  localparam int TS2 = 6;
  localparam int TS3 = 12;
  localparam int G   = TS3 + 4;
  localparam int H   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, dq0 = 1'b0;
  logic wrsr_busy = 1'b0, wnvcr_busy = 1'b0, op_active = 1'b0, op_susp = 1'b0;
  logic [15:0] nv_cfg = '0;
  logic rst_pulse, vol_clr, abort_op, flag_rdy;
  logic [7:0] vcr_dflt, evcr_dflt, ear_dflt;

  int total = 0, bad = 0;
  int n_rst = 0, n_clr = 0, n_abt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_rst_seq #(.SYNC_STAGES(2), .DESEL_MIN(TS2), .RECOV_MIN(TS3)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .dq0(dq0),
    .wrsr_busy(wrsr_busy), .wnvcr_busy(wnvcr_busy), .op_active(op_active),
    .op_susp(op_susp), .nv_cfg(nv_cfg), .rst_pulse(rst_pulse), .vol_clr(vol_clr),
    .abort_op(abort_op), .flag_rdy(flag_rdy), .vcr_dflt(vcr_dflt),
    .evcr_dflt(evcr_dflt), .ear_dflt(ear_dflt));

  always @(negedge clk) begin
    if (rst_pulse) n_rst++;
    if (vol_clr)   n_clr++;
    if (abort_op)  n_abt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic frame(input logic [7:0] code, input int nbits, input int gap);
    logic [7:0] sh;
    sh = code;
    repeat (gap) @(negedge clk);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      dq0 = sh[7];
      sh  = {sh[6:0], 1'b0};
      repeat (H) @(negedge clk);
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic settle();
    repeat (TS3 + 8) @(negedge clk);
  endtask

  initial begin
    int base, abase;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 / R6: reset state
    chk("R11 rst_pulse", int'(rst_pulse), 0);
    chk("R11 vol_clr", int'(vol_clr), 0);
    chk("R11 abort_op", int'(abort_op), 0);
    chk("R6 flag after reset", int'(flag_rdy), 1);
    frame(8'h99, 8, G); settle();
    chk("R11 unarmed after reset", n_rst, 0);

    // R8: defaults from configuration word
    for (int i = 0; i < 64; i++) begin
      v = 16'(i * 1237 + (i << 9));
      nv_cfg = v; #1;
      chk("R8 vcr", int'(vcr_dflt), int'({v[15:12], 4'hB}));
      chk("R8 evcr", int'(evcr_dflt), (int'(v[3:2]) << 6) | 48 | (int'(v[4]) << 3) | 7);
      chk("R8 ear", int'(ear_dflt), int'(v[1]));
    end

    // R2 / R7 / R6: basic sequence
    base = n_rst;
    frame(8'h66, 8, G); frame(8'h99, 8, G);
    repeat (6) @(negedge clk);
    chk("R2 basic fire", n_rst - base, 1);
    chk("R7 clear strobe count", n_clr, n_rst);
    chk("R6 flag low in recovery", int'(flag_rdy), 0);
    repeat (TS3 + 8) @(negedge clk);
    chk("R6 flag back high", int'(flag_rdy), 1);

    // R4: deselect gap sweep
    for (int g = TS2 - 2; g <= TS2 + 2; g++) begin
      base = n_rst;
      frame(8'h66, 8, G); frame(8'h99, 8, g); settle();
      chk("R4 gap sweep", n_rst - base, (g >= TS2) ? 1 : 0);
      base = n_rst;
      frame(8'h99, 8, G); settle();
      chk("R3 arm gone after exec", n_rst - base, 0);
    end

    // R3: every opcode between arm and execute
    for (int op = 0; op < 256; op++) begin
      base = n_rst;
      frame(8'h66, 8, G); frame(8'(op), 8, G); frame(8'h99, 8, G); settle();
      chk("R3 opcode sweep", n_rst - base, (op == 'h66 || op == 'h99) ? 1 : 0);
    end

    // R1: partial and long selections
    base = n_rst;
    frame(8'h66, 8, G); frame(8'h99, 4, G); frame(8'h99, 8, G); settle();
    chk("R1 partial keeps arm", n_rst - base, 1);
    base = n_rst;
    frame(8'h66, 5, G); frame(8'h99, 8, G); settle();
    chk("R1 partial arm discarded", n_rst - base, 0);
    base = n_rst;
    frame(8'h66, 12, G); frame(8'h99, 10, G); settle();
    chk("R1 extra bits ignored", n_rst - base, 1);

    // R10: busy refuses arming
    for (int b = 0; b < 4; b++) begin
      base = n_rst;
      wrsr_busy = b[0]; wnvcr_busy = b[1];
      frame(8'h66, 8, G);
      repeat (6) @(negedge clk);
      wrsr_busy = 1'b0; wnvcr_busy = 1'b0;
      frame(8'h99, 8, G); settle();
      chk("R10 busy sweep", n_rst - base, (b == 0) ? 1 : 0);
    end
    base = n_rst;
    frame(8'h66, 8, G);
    wnvcr_busy = 1'b1;
    frame(8'h66, 8, G);
    repeat (6) @(negedge clk);
    wnvcr_busy = 1'b0;
    frame(8'h99, 8, G); settle();
    chk("R10 refused arm clears earlier", n_rst - base, 0);

    // R9: abort qualifier
    for (int a = 0; a < 4; a++) begin
      base = n_rst; abase = n_abt;
      op_active = a[0]; op_susp = a[1];
      frame(8'h66, 8, G); frame(8'h99, 8, G); settle();
      op_active = 1'b0; op_susp = 1'b0;
      chk("R9 fire", n_rst - base, 1);
      chk("R9 abort sweep", n_abt - abase, (a != 0) ? 1 : 0);
    end

    // R5: recovery window boundary
    for (int r = TS3 - 1; r <= TS3 + 1; r++) begin
      base = n_rst;
      frame(8'h66, 8, G); frame(8'h99, 8, G);
      frame(8'h66, 8, r); frame(8'h99, 8, G); settle();
      chk("R5 recovery sweep", n_rst - base, (r > TS3) ? 2 : 1);
    end

    chk("R7 clear strobe total", n_clr, n_rst);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule